// File: doc/BRIEF.md
# DC-Balanced Embedded-Clock Frame Encoder

This block turns one pixel (a 24-bit data word plus the VS, HS and DE video control levels) into a 28-bit serial frame. It sends that frame one bit at a time on a fast-clock enable. Every frame opens with a fixed high-then-low bit pair. The receiver uses this pair to recover the clock edge.

The pixel data is first whitened with an additive LFSR keystream. The encoder then decides whether to invert the payload so that the running DC disparity of the line stays small, and it reports that choice in a balance flag. The frame closes with a check bit. This bit is the parity of the frame tail and one control level, taken in turn, so each control signal travels at one third of the pixel rate.

The block runs on a single clock `clk`, and `bit_tick` marks each bit time. A tick loads a new frame when the previous frame's last bit has been shown, and also on the first tick after reset. Only on that loading tick are the pixel inputs and control levels sampled. One clock cycle after each load, `frame_start` pulses.

Top module: `link_frame_encoder`

## Requirements
- R1: Each frame's first two serial bits are 1 then 0, and `ser_out` is 1 whenever `frame_start` is high.
- R2: Frame bits 25..2 (MSB first after the clock pair) carry `pix_data[23:0]` XOR a keystream when not inverted. Keystream bit for data bit 23-k (k = 0..23) is LFSR state bit 15 before step k. One step shifts the state left by one and inserts bit15^bit4^bit3^bit2 at bit 0. The state resets to 16'hACE1 and advances 24 steps per frame.
- R3: Let D = 2*ones - 24 be the disparity of the scrambled payload, and let RD be the running disparity. The payload is sent inverted exactly when D is nonzero, RD is nonzero, and both have the same sign.
- R4: Frame bit 1 (second to last) is 1 for an inverted payload and 0 otherwise.
- R5: RD starts at 0 on reset. After each frame, RD gains the disparity of the payload as actually sent, so it stays within ±24.
- R6: Frame bit 0 is the XOR of the 24 sent payload bits, the balance bit and one control level. The level is chosen in turn VS, HS, DE, starting from VS after reset and advancing one step per frame.
- R7: `ser_out` changes only on a cycle with `bit_tick` high, and it moves one frame bit per tick.
- R8: Pixel and control inputs are sampled only on the loading tick, and changes at any other time have no effect. `frame_start` is high for exactly the one cycle after the loading tick.
- R9: While and just after reset, `ser_out` and `frame_start` are 0 until the first tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_tick | input | 1 | Bit-time enable, 28 per frame |
| pix_data | input | 24 | Pixel data word |
| pix_vs | input | 1 | Vertical sync level |
| pix_hs | input | 1 | Horizontal sync level |
| pix_de | input | 1 | Data enable level |
| ser_out | output | 1 | Serial frame bit, MSB first |
| frame_start | output | 1 | One-cycle pulse after each frame load |

## Verification
The hardest case to reach is a chosen running disparity. The payload on the wire is scrambled, so no raw input pattern gives a known disparity. The bench therefore previews the keystream from its own LFSR model. It drives data equal to the wanted payload XOR that keystream, which lets it produce all-ones, all-zeros and exactly balanced payloads on demand. This walks RD through zero and ±24, where the "sign is zero" corner of the inversion rule decides the outcome.

// File: rtl/lfe_pkg.sv
package lfe_pkg;
   // fixed embedded clock pair sent ahead of every payload
   localparam logic [1:0] CLK_PAIR = 2'b10;
   // overhead bits per frame: clock pair, balance flag, check bit
   localparam int FRAME_OVERHEAD = 4;

   function automatic int disp_width(input int data_w);
      return $clog2(data_w + 1) + 2;
   endfunction
endpackage

// File: rtl/lfe_scrambler.sv
module lfe_scrambler #(
   parameter int                DATA_W = 24,
   parameter int                LFSR_W = 16,
   parameter logic [LFSR_W-1:0] TAPS   = 16'h801C,
   parameter logic [LFSR_W-1:0] SEED   = 16'hACE1,
   parameter bit                ENABLE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              advance,
   input  logic [DATA_W-1:0] data_i,
   output logic [DATA_W-1:0] data_o
);
   logic [LFSR_W-1:0] state_q;
   logic [LFSR_W-1:0] state_nx;
   logic [DATA_W-1:0] keystream;

   always_comb begin
      logic [LFSR_W-1:0] st;
      logic              fb;
      st = state_q;
      keystream = '0;
      for (int k = 0; k < DATA_W; k++) begin
         keystream[DATA_W-1-k] = st[LFSR_W-1];
         fb = ^(st & TAPS);
         st = {st[LFSR_W-2:0], fb};
      end
      state_nx = st;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)       state_q <= SEED;
      else if (advance) state_q <= state_nx;
   end

   generate
      if (ENABLE) begin : g_scramble
         assign data_o = data_i ^ keystream;
      end else begin : g_bypass
         assign data_o = data_i ^ (keystream & '0);
      end
   endgenerate

   AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      state_q != '0);  // R2
endmodule

// File: rtl/lfe_dc_balancer.sv
module lfe_dc_balancer #(
   parameter int DATA_W = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              advance,
   input  logic [DATA_W-1:0] payload_i,
   output logic [DATA_W-1:0] payload_o,
   output logic              invert_o
);
   localparam int RD_W  = lfe_pkg::disp_width(DATA_W);
   localparam int CNT_W = $clog2(DATA_W + 1);

   logic [CNT_W-1:0]       ones;
   logic signed [RD_W-1:0] pay_disp;
   logic signed [RD_W-1:0] rd_q;
   logic signed [RD_W-1:0] rd_nx;

   always_comb begin
      ones     = CNT_W'($countones(payload_i));
      pay_disp = $signed(RD_W'({ones, 1'b0})) - $signed(RD_W'(DATA_W));
      invert_o = (pay_disp != 0) && (rd_q != 0) &&
                 (pay_disp[RD_W-1] == rd_q[RD_W-1]);
      payload_o = invert_o ? ~payload_i : payload_i;
      rd_nx     = invert_o ? (rd_q - pay_disp) : (rd_q + pay_disp);
   end

   always_ff @(posedge clk) begin
      if (!rst_n)       rd_q <= '0;
      else if (advance) rd_q <= rd_nx;
   end

   AST_RD_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_q <= $signed(RD_W'(DATA_W))) && (rd_q >= -$signed(RD_W'(DATA_W))));  // R5
endmodule

// File: rtl/lfe_ctrl_fold.sv
module lfe_ctrl_fold #(
   parameter int CTRL_N = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              advance,
   input  logic [CTRL_N-1:0] ctrl_i,
   output logic              bit_o
);
   logic [CTRL_N-1:0] sel_q;

   always_ff @(posedge clk) begin
      if (!rst_n)       sel_q <= CTRL_N'(1) << (CTRL_N - 1);
      else if (advance) sel_q <= {sel_q[0], sel_q[CTRL_N-1:1]};
   end

   assign bit_o = ^(ctrl_i & sel_q);

   AST_ONE_CTRL_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(sel_q) == 1);  // R6
endmodule

// File: rtl/lfe_serializer.sv
module lfe_serializer #(
   parameter int FRAME_LEN = 28
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bit_tick,
   input  logic [FRAME_LEN-1:0] frame_i,
   output logic                 load_o,
   output logic                 ser_o,
   output logic                 frame_start_o
);
   localparam int SLOT_W = $clog2(FRAME_LEN);
   localparam logic [SLOT_W-1:0] LAST = SLOT_W'(FRAME_LEN - 1);

   logic [SLOT_W-1:0]    slot_q;
   logic [FRAME_LEN-1:0] shift_q;
   logic                 fs_q;

   assign load_o = bit_tick && (slot_q == LAST);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         slot_q  <= LAST;
         shift_q <= '0;
         fs_q    <= 1'b0;
      end else begin
         fs_q <= load_o;
         if (load_o) begin
            slot_q  <= '0;
            shift_q <= frame_i;
         end else if (bit_tick) begin
            slot_q  <= slot_q + 1'b1;
            shift_q <= {shift_q[FRAME_LEN-2:0], 1'b0};
         end
      end
   end

   assign ser_o         = shift_q[FRAME_LEN-1];
   assign frame_start_o = fs_q;

   AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      slot_q <= LAST);  // R7
   AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(bit_tick) |-> $stable(ser_o));  // R7
   AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start_o |=> !frame_start_o);  // R8
endmodule

// File: rtl/link_frame_encoder.sv
module link_frame_encoder #(
   parameter int                DATA_W      = 24,
   parameter int                LFSR_W      = 16,
   parameter logic [LFSR_W-1:0] LFSR_TAPS   = 16'h801C,
   parameter logic [LFSR_W-1:0] LFSR_SEED   = 16'hACE1,
   parameter bit                SCRAMBLE_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_tick,
   input  logic [DATA_W-1:0] pix_data,
   input  logic              pix_vs,
   input  logic              pix_hs,
   input  logic              pix_de,
   output logic              ser_out,
   output logic              frame_start
);
   localparam int CTRL_N    = 3;
   localparam int FRAME_LEN = DATA_W + lfe_pkg::FRAME_OVERHEAD;

   if (DATA_W < 2 || (DATA_W % 2) != 0) begin : g_bad_data_w
      $error("link_frame_encoder: DATA_W must be even and at least 2");
   end
   if (LFSR_W < 2) begin : g_bad_lfsr_w
      $error("link_frame_encoder: LFSR_W must be at least 2");
   end
   if (LFSR_SEED == '0) begin : g_bad_seed
      $error("link_frame_encoder: LFSR_SEED must be nonzero");
   end

   logic                 load;
   logic [DATA_W-1:0]    scrambled;
   logic [DATA_W-1:0]    sent;
   logic                 invert;
   logic                 ctrl_bit;
   logic                 check_bit;
   logic [FRAME_LEN-1:0] frame;

   lfe_scrambler #(
      .DATA_W(DATA_W), .LFSR_W(LFSR_W), .TAPS(LFSR_TAPS),
      .SEED(LFSR_SEED), .ENABLE(SCRAMBLE_EN)
   ) u_scr (
      .clk(clk), .rst_n(rst_n), .advance(load),
      .data_i(pix_data), .data_o(scrambled)
   );

   lfe_dc_balancer #(.DATA_W(DATA_W)) u_bal (
      .clk(clk), .rst_n(rst_n), .advance(load),
      .payload_i(scrambled), .payload_o(sent), .invert_o(invert)
   );

   lfe_ctrl_fold #(.CTRL_N(CTRL_N)) u_ctl (
      .clk(clk), .rst_n(rst_n), .advance(load),
      .ctrl_i({pix_vs, pix_hs, pix_de}), .bit_o(ctrl_bit)
   );

   assign check_bit = (^sent) ^ invert ^ ctrl_bit;
   assign frame     = {lfe_pkg::CLK_PAIR, sent, invert, check_bit};

   lfe_serializer #(.FRAME_LEN(FRAME_LEN)) u_ser (
      .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .frame_i(frame),
      .load_o(load), .ser_o(ser_out), .frame_start_o(frame_start)
   );

   AST_CLK_PAIR_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |-> ser_out);  // R1
endmodule

// File: tb/sim_link_frame_encoder.sv
module sim_link_frame_encoder;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bit_tick = 1'b0;
   logic [23:0] pix_data = '0;
   logic        pix_vs = 1'b0, pix_hs = 1'b0, pix_de = 1'b0;
   logic        ser_out, frame_start;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   logic [15:0] m_lfsr;
   int          m_rd;
   int          m_rr;
   logic        last_inv;

   always #10 clk = ~clk;

   link_frame_encoder u0 (
      .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .pix_data(pix_data),
      .pix_vs(pix_vs), .pix_hs(pix_hs), .pix_de(pix_de),
      .ser_out(ser_out), .frame_start(frame_start)
   );

   task automatic chk(input bit ok, input string req,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [23:0] ks_of(input logic [15:0] s);
      logic [23:0] r;
      logic        fb;
      for (int k = 0; k < 24; k++) begin
         r[23-k] = s[15];
         fb = s[15] ^ s[4] ^ s[3] ^ s[2];
         s = {s[14:0], fb};
      end
      return r;
   endfunction

   function automatic logic [15:0] adv_of(input logic [15:0] s);
      logic fb;
      for (int k = 0; k < 24; k++) begin
         fb = s[15] ^ s[4] ^ s[3] ^ s[2];
         s = {s[14:0], fb};
      end
      return s;
   endfunction

   task automatic model_frame(input logic [23:0] d, input logic v, h, e,
                              output logic [27:0] f);
      logic [23:0] p;
      int          dd;
      logic        inv, cb;
      p  = d ^ ks_of(m_lfsr);
      m_lfsr = adv_of(m_lfsr);
      dd = 2 * $countones(p) - 24;
      inv = (dd != 0) && (m_rd != 0) && ((dd > 0) == (m_rd > 0));
      if (inv) begin p = ~p; m_rd = m_rd - dd; end
      else     m_rd = m_rd + dd;
      cb = (m_rr == 0) ? v : (m_rr == 1) ? h : e;
      m_rr = (m_rr + 1) % 3;
      last_inv = inv;
      f = {2'b10, p, inv, (^p) ^ inv ^ cb};
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; bit_tick = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      m_lfsr = 16'hACE1; m_rd = 0; m_rr = 0;
   endtask

   // sends one frame, gap idle cycles between ticks; returns balance bit
   task automatic send_frame(input logic [23:0] d, input logic v, h, e,
                             input int gap, output logic inv_bit);
      logic [27:0] exp_f, got;
      model_frame(d, v, h, e, exp_f);
      @(negedge clk);
      pix_data = d; pix_vs = v; pix_hs = h; pix_de = e;
      bit_tick = 1'b1;
      @(negedge clk);
      bit_tick = 1'b0;
      // garbage on inputs mid-frame must not matter (R8)
      pix_data = ~d; pix_vs = ~v; pix_hs = ~h; pix_de = ~e;
      chk(frame_start === 1'b1, "R8 frame_start after load", 32'(frame_start), 1);
      got[27] = ser_out;
      for (int g = 0; g < gap; g++) begin
         @(negedge clk);
         chk(ser_out === got[27], "R7 hold without tick", 32'(ser_out), 32'(got[27]));
      end
      for (int i = 1; i < 28; i++) begin
         bit_tick = 1'b1;
         @(negedge clk);
         bit_tick = 1'b0;
         got[27-i] = ser_out;
         if (i == 1)
            chk(frame_start === 1'b0, "R8 frame_start one cycle", 32'(frame_start), 0);
         for (int g = 0; g < gap; g++) begin
            @(negedge clk);
            chk(ser_out === got[27-i], "R7 hold without tick", 32'(ser_out), 32'(got[27-i]));
         end
      end
      chk(got[27:26] === 2'b10, "R1 clock pair", 32'(got[27:26]), 2);
      chk(got[25:2] === exp_f[25:2], "R2 R3 payload", 32'(got[25:2]), 32'(exp_f[25:2]));
      chk(got[1] === exp_f[1], "R4 balance bit", 32'(got[1]), 32'(exp_f[1]));
      chk(got[0] === exp_f[0], "R6 check bit", 32'(got[0]), 32'(exp_f[0]));
      inv_bit = got[1];
   endtask

   task automatic t_reset_state();
      do_reset();
      repeat (4) begin
         @(negedge clk);
         chk(ser_out === 1'b0, "R9 ser_out idle", 32'(ser_out), 0);
         chk(frame_start === 1'b0, "R9 frame_start idle", 32'(frame_start), 0);
      end
   endtask

   task automatic t_basic();
      logic b;
      do_reset();
      send_frame(24'h000000, 1, 0, 1, 0, b);
      send_frame(24'hFFFFFF, 0, 1, 1, 0, b);
      send_frame(24'hA5A5A5, 1, 1, 0, 2, b);
      send_frame(24'h123456, 0, 0, 1, 1, b);
      send_frame(24'h0F0F0F, 1, 0, 0, 0, b);
   endtask

   task automatic t_balance();
      logic b;
      do_reset();
      // all-ones payload from RD=0: not inverted, RD=24
      send_frame(24'hFFFFFF ^ ks_of(m_lfsr), 0, 0, 0, 0, b);
      chk(b === 1'b0, "R5 first ones not inverted", 32'(b), 0);
      send_frame(24'hFFFFFF ^ ks_of(m_lfsr), 0, 0, 0, 0, b);
      chk(b === 1'b1, "R5 second ones inverted", 32'(b), 1);
      // RD back at 0: all-zeros payload not inverted (RD zero), RD=-24
      send_frame(24'h000000 ^ ks_of(m_lfsr), 0, 0, 0, 0, b);
      chk(b === 1'b0, "R3 zero RD keeps payload", 32'(b), 0);
      // balanced payload with RD=-24 is never inverted
      send_frame(24'h000FFF ^ ks_of(m_lfsr), 1, 1, 1, 0, b);
      chk(b === 1'b0, "R3 zero disparity keeps payload", 32'(b), 0);
      send_frame(24'h000000 ^ ks_of(m_lfsr), 0, 0, 0, 0, b);
      chk(b === 1'b1, "R5 negative RD remembered", 32'(b), 1);
   endtask

   task automatic t_control_rr();
      logic b;
      do_reset();
      for (int f = 0; f < 6; f++)
         send_frame(24'h3C3C3C, 0, 1, 0, 0, b);
      for (int f = 0; f < 3; f++)
         send_frame(24'h777777, 1, 0, 1, 0, b);
   endtask

   task automatic t_reset_mid();
      logic b;
      logic [27:0] exp_f, got;
      do_reset();
      send_frame(24'hDEADBE, 1, 1, 1, 0, b);
      @(negedge clk); pix_data = 24'h111111; bit_tick = 1'b1;
      repeat (5) @(negedge clk);
      bit_tick = 1'b0;
      do_reset();
      chk(ser_out === 1'b0, "R9 ser_out after mid reset", 32'(ser_out), 0);
      model_frame(24'h000000, 1, 0, 0, exp_f);
      @(negedge clk);
      pix_data = '0; pix_vs = 1; pix_hs = 0; pix_de = 0; bit_tick = 1'b1;
      for (int i = 0; i < 28; i++) begin
         @(negedge clk);
         got[27-i] = ser_out;
      end
      bit_tick = 1'b0;
      chk(got[25:2] === ks_of(16'hACE1), "R2 keystream reseeded", 32'(got[25:2]),
          32'(ks_of(16'hACE1)));
      chk(got === exp_f, "R6 frame after mid reset", 32'(got), 32'(exp_f));
   endtask

   initial begin
      t_reset_state();
      t_basic();
      t_balance();
      t_control_rr();
      t_reset_mid();
      if (!finished) begin
         finished = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      #(20 * 150000);
      if (!finished) begin
         finished = 1'b1;
         n_chk++; n_fail++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end
endmodule